// File: doc/BRIEF.md
# Register-Programmed Serial Transfer Master

This block lets a host run short serial transfers on a four-wire, SPI-style bus through three 32-bit word registers. The host picks a target device and a bit-rate class in the select/status word, loads the data word, and then writes the control word. That last write launches a transfer of one to four bytes, most significant bit first. The transfer can send the data word, receive into it, or do both at once.

Chip select follows the device-select field. It stays asserted from one transfer to the next until the host writes that field back to zero, so several transfers form one transaction. When the last bit has moved, the block sets a completion flag in the select/status word. The host polls that flag and clears it with a write-one-to-clear. The serial clock is a division of a 64 MHz system clock (parameter `SYS_MHZ`) and runs at 1 to 32 MHz.

Top module: `sbm_top`

## Requirements
- R1: After synchronous reset all three registers read zero, every chip-select line is high (inactive), the serial clock is low and the serial output is low.
- R2: Bits 9..7 of the select/status word (offset 0) drive the chip-select lines: bit 7+i set pulls `cs_n[i]` low. Chip select stays low across and between transfers as long as the bit stays set, and writing the field to zero releases all lines.
- R3: Bits 6..4 of the select/status word choose the serial-clock period. Code k in 0..5 gives a period of 2*((SYS_MHZ/2)>>k) system cycles, which is 64, 32, 16, 8, 4 and 2 cycles at the default. Codes 6 and 7 act as code 5. The code is latched when a transfer starts, so a change during a transfer does not alter that transfer.
- R4: In the control word (offset 12), bit 0 is start and bit 1 is the mode. Only mode 0 (immediate) launches a transfer. A start written with mode 1 launches nothing: no clock edge appears, the completion flag stays clear and start reads back 0.
- R5: Control bits 5..4 hold the length code L, and a transfer moves (L+1)*8 bits. Transmitted bits come from the data word starting at bit 31 and going downward.
- R6: Control bits 3..2 hold the kind: 0 receive, 1 send, 2 exchange, 3 treated as send. After a receive or an exchange, the data word holds the received bits right-aligned, with zeros above them. A send leaves the data word unchanged and ignores the serial input. A receive holds the serial output low.
- R7: The serial clock idles low. The serial output changes only while the clock is low (after a falling edge), and the serial input is sampled on the rising edge.
- R8: Start (control bit 0) reads 1 while a transfer runs and 0 once it ends. At the end, bit 3 of the select/status word sets. Writing 1 to bit 3 clears it, and writing 0 there leaves it unchanged.
- R9: While a transfer runs, writes to the data word and to the control word are ignored.
- R10: Registers sit at byte offsets 0, 12 and 16. Any other offset reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cs_n | output | 3 | Active-low chip selects, one per device |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
A short transfer must stop after exactly 8 or 16 bits and right-align what it received. A design that counts a fixed 32 bits, or that leaves the result left-aligned, returns the wrong word. Send transfers must leave the data word untouched and receive transfers must keep MOSI low; a design that mixes up the kind codes corrupts one or the other. Writes to the data, control and clock-select fields in the middle of a transfer must not change the running bit stream, its length or its period; a design that latches late shows a changed period or an overwritten word. A start written with mode 1, a write of 0 to the completion flag and a select write that leaves the device bit set must each change nothing, so a design that launches anyway, clears the flag or drops chip select between transfers is caught at the pins.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BIT_W   = $clog2(WORD_W + 1);
    localparam int unsigned NUM_DEV = 3;
    localparam int unsigned ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_STAT = 5'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'd12;
    localparam logic [ADDR_W-1:0] OFS_DATA = 5'd16;

    typedef enum logic [1:0] {
        KIND_RX  = 2'd0,
        KIND_TX  = 2'd1,
        KIND_XCH = 2'd2,
        KIND_TX2 = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [BIT_W-1:0] nbits;
        logic             drive;
        logic [2:0]       rate;
    } xfer_cfg_t;

    function automatic int unsigned half_cycles(logic [2:0] rate, int unsigned sys_mhz);
        int unsigned s;
        int unsigned h;
        s = (rate > 3'd5) ? 5 : int'(rate);
        h = (sys_mhz / 2) >> s;
        return (h == 0) ? 1 : h;
    endfunction

    function automatic logic [BIT_W-1:0] len_bits(logic [1:0] code);
        return BIT_W'((int'(code) + 1) * 8);
    endfunction

endpackage

// File: rtl/sbm_engine.sv
module sbm_engine
    import sbm_pkg::*;
#(
    parameter int unsigned SYS_MHZ = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_cfg_t         cfg,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              done_pulse,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi
);
    localparam int unsigned HP_W = $clog2(SYS_MHZ / 2 + 1);

    logic              busy_q, done_q, sclk_q, drive_q;
    logic [HP_W-1:0]   cnt_q, hp_q;
    logic [BIT_W-1:0]  bit_q, nb_q;
    logic [WORD_W-1:0] tx_q, rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            sclk_q  <= 1'b0;
            drive_q <= 1'b0;
            cnt_q   <= '0;
            hp_q    <= '0;
            bit_q   <= '0;
            nb_q    <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q  <= 1'b1;
                sclk_q  <= 1'b0;
                cnt_q   <= '0;
                bit_q   <= '0;
                tx_q    <= tx_word;
                rx_q    <= '0;
                hp_q    <= HP_W'(half_cycles(cfg.rate, SYS_MHZ));
                nb_q    <= cfg.nbits;
                drive_q <= cfg.drive;
            end else if (busy_q) begin
                if (cnt_q == hp_q - 1'b1) begin
                    cnt_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[WORD_W-2:0], miso};
                    end else begin
                        sclk_q <= 1'b0;
                        tx_q   <= tx_q << 1;
                        if (bit_q == nb_q - 1'b1) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign busy       = busy_q;
    assign done_pulse = done_q;
    assign rx_word    = rx_q;
    assign sclk       = sclk_q;
    assign mosi       = busy_q & drive_q & tx_q[WORD_W-1];

    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sclk_q);
    assert_mosi_low_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && sclk_q) |=> $stable(mosi) || !sclk_q);
    assert_bit_range_R5: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (bit_q < nb_q));
    assert_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);

endmodule

// File: rtl/sbm_regs.sv
module sbm_regs
    import sbm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               busy,
    input  logic               done_pulse,
    input  logic [WORD_W-1:0]  rx_word,
    output logic               start,
    output xfer_cfg_t          cfg,
    output logic [WORD_W-1:0]  tx_word,
    output logic [NUM_DEV-1:0] dev_sel
);
    logic [NUM_DEV-1:0] sel_q;
    logic [2:0]         rate_q;
    logic               done_q, mode_q, capture_q;
    logic [1:0]         len_q;
    xfer_kind_e         kind_q, kind_w;
    logic [WORD_W-1:0]  data_q;
    logic               wr_stat, wr_ctrl, wr_data;
    logic               unused_wbits;

    assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL) && !busy;
    assign wr_data = bus_wr && (bus_addr == OFS_DATA) && !busy;
    assign kind_w  = xfer_kind_e'(bus_wdata[3:2]);

    assign start     = wr_ctrl && bus_wdata[0] && !bus_wdata[1];
    assign cfg.nbits = len_bits(bus_wdata[5:4]);
    assign cfg.drive = (kind_w != KIND_RX);
    assign cfg.rate  = rate_q;
    assign tx_word   = data_q;
    assign dev_sel   = sel_q;
    assign unused_wbits = ^{bus_wdata[WORD_W-1:10]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            rate_q    <= '0;
            done_q    <= 1'b0;
            mode_q    <= 1'b0;
            len_q     <= '0;
            kind_q    <= KIND_RX;
            capture_q <= 1'b0;
            data_q    <= '0;
        end else begin
            if (wr_stat) begin
                sel_q  <= bus_wdata[9:7];
                rate_q <= bus_wdata[6:4];
                if (bus_wdata[3]) done_q <= 1'b0;
            end
            if (wr_ctrl) begin
                len_q  <= bus_wdata[5:4];
                kind_q <= kind_w;
                mode_q <= bus_wdata[1];
            end
            if (start) capture_q <= (kind_w == KIND_RX) || (kind_w == KIND_XCH);
            if (wr_data) data_q <= bus_wdata;
            if (done_pulse) begin
                done_q <= 1'b1;
                if (capture_q) data_q <= rx_word;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_STAT: bus_rdata = {22'd0, sel_q, rate_q, done_q, 3'd0};
            OFS_CTRL: bus_rdata = {26'd0, len_q, kind_q, mode_q, busy};
            OFS_DATA: bus_rdata = data_q;
            default:  bus_rdata = '0;
        endcase
    end

    assert_data_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(data_q));
    assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(len_q) && $stable(kind_q) && $stable(mode_q)));
    assert_mode1_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[1] && !busy) |=> !busy);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && bus_wdata[3] && !done_pulse) |=> !done_q);
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (done_q && !(wr_stat && bus_wdata[3])) |=> done_q);

endmodule

// File: rtl/sbm_top.sv
module sbm_top
    import sbm_pkg::*;
#(
    parameter int unsigned SYS_MHZ = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [2:0]  cs_n,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso
);
    logic               start, busy, done_pulse;
    xfer_cfg_t          cfg;
    logic [WORD_W-1:0]  tx_word, rx_word;
    logic [NUM_DEV-1:0] dev_sel;

    sbm_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rx_word    (rx_word),
        .start      (start),
        .cfg        (cfg),
        .tx_word    (tx_word),
        .dev_sel    (dev_sel)
    );

    sbm_engine #(.SYS_MHZ(SYS_MHZ)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cfg        (cfg),
        .tx_word    (tx_word),
        .miso       (miso),
        .busy       (busy),
        .done_pulse (done_pulse),
        .rx_word    (rx_word),
        .sclk       (sclk),
        .mosi       (mosi)
    );

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_cs
        assign cs_n[d] = ~dev_sel[d];
    end

    assert_cs_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_wr) |=> $stable(cs_n));

endmodule

// File: tb/sbm_top_tb_top.sv
`timescale 1ns/1ps
module sbm_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  cs_n;
    logic        sclk, mosi, miso;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_rise = 0;
    int gap = 0;
    int rise_cnt = 0;
    int mosi_bad = 0;
    logic        mosi_prev = 1'b0;
    logic [31:0] sl_sh = '0;
    logic [31:0] mosi_cap = '0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    sbm_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    assign miso = sl_sh[31];

    always @(posedge clk) cyc = cyc + 1;
    always @(posedge sclk) begin
        gap = cyc - last_rise;
        last_rise = cyc;
        rise_cnt = rise_cnt + 1;
        mosi_cap = {mosi_cap[30:0], mosi};
    end
    always @(negedge sclk) sl_sh = sl_sh << 1;
    always @(negedge clk) begin
        if (mosi !== mosi_prev && sclk) mosi_bad = mosi_bad + 1;
        mosi_prev = mosi;
    end

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_read(5'd0, s);
            if (s[3]) break;
        end
    endtask

    task automatic launch(input logic [2:0] rate, input logic [1:0] kind, input logic [1:0] len,
                          input logic [31:0] tx, input logic [31:0] slv);
        bus_write(5'd0, 32'h100 | (32'(rate) << 4) | 32'h8);
        bus_write(5'd16, tx);
        sl_sh = slv;
        mosi_cap = '0;
        bus_write(5'd12, (32'(len) << 4) | (32'(kind) << 2) | 32'h1);
    endtask

    // {rate, kind, len, tx word, word the device returns}
    localparam logic [70:0] VEC [8] = '{
        {3'd5, 2'd1, 2'd3, 32'hA5C30F81, 32'h00000000},
        {3'd5, 2'd0, 2'd3, 32'hFFFFFFFF, 32'h12345678},
        {3'd3, 2'd2, 2'd3, 32'h80000001, 32'hCAFEF00D},
        {3'd4, 2'd0, 2'd0, 32'h00000000, 32'h9E000000},
        {3'd2, 2'd1, 2'd1, 32'hBEEF1234, 32'h00000000},
        {3'd0, 2'd2, 2'd2, 32'h12345600, 32'h876543FF},
        {3'd7, 2'd3, 2'd3, 32'h0F0F0F0F, 32'hFFFFFFFF},
        {3'd1, 2'd0, 2'd3, 32'h00000000, 32'h00000001}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        bus_read(5'd0, rd);  check(rd == 0, "R1 status", rd, 0);
        bus_read(5'd12, rd); check(rd == 0, "R1 control", rd, 0);
        bus_read(5'd16, rd); check(rd == 0, "R1 data", rd, 0);
        check({cs_n, sclk, mosi} == 5'b11100, "R1 pins", 32'({cs_n, sclk, mosi}), 32'h1C);

        // R2 select field to chip selects
        bus_write(5'd0, 32'h080); check(cs_n == 3'b110, "R2 dev0", 32'(cs_n), 32'h6);
        bus_write(5'd0, 32'h200); check(cs_n == 3'b011, "R2 dev2", 32'(cs_n), 32'h3);

        // R10 decode
        bus_write(5'd16, 32'h11223344);
        bus_write(5'd8, 32'hFFFFFFFF);
        bus_read(5'd16, rd); check(rd == 32'h11223344, "R10 data offset", rd, 32'h11223344);
        bus_read(5'd8, rd);  check(rd == 0, "R10 hole reads zero", rd, 0);
        bus_read(5'd4, rd);  check(rd == 0, "R10 hole 4", rd, 0);

        // Vector table: R3 period, R5 length/order, R6 kind, R8 flag
        for (int v = 0; v < 8; v++) begin
            logic [2:0]  rate;
            logic [1:0]  kind, len;
            logic [31:0] tx, slv, e_mosi, e_data;
            int n, e_gap;
            {rate, kind, len, tx, slv} = VEC[v];
            n = (int'(len) + 1) * 8;
            e_gap = 64 >> ((rate > 3'd5) ? 5 : int'(rate));
            e_mosi = (kind == 2'd0) ? 32'h0 : (tx >> (32 - n));
            e_data = (kind == 2'd0 || kind == 2'd2) ? (slv >> (32 - n)) : tx;
            launch(rate, kind, len, tx, slv);
            wait_done();
            bus_read(5'd0, rd);  check(rd[3] == 1'b1, "R8 flag set", rd, 32'h8);
            check(mosi_cap == e_mosi, "R5 R6 bits sent", mosi_cap, e_mosi);
            bus_read(5'd16, rd); check(rd == e_data, "R6 data word", rd, e_data);
            check(gap == e_gap, "R3 sclk period", 32'(gap), 32'(e_gap));
            check(sclk == 1'b0, "R7 idle low", 32'(sclk), 0);
        end

        // R2 chip select kept between transfers, R8 write-one-to-clear
        check(cs_n == 3'b101, "R2 held after transfer", 32'(cs_n), 32'h5);
        bus_write(5'd0, 32'h150);
        bus_read(5'd0, rd); check(rd[3] == 1'b1, "R8 write 0 keeps flag", rd, 32'h158);
        bus_write(5'd0, 32'h158);
        bus_read(5'd0, rd); check(rd[3] == 1'b0, "R8 write 1 clears flag", rd, 32'h150);
        check(cs_n == 3'b101, "R2 held after clear", 32'(cs_n), 32'h5);

        // R9 / R3 writes during a transfer
        launch(3'd0, 2'd1, 2'd3, 32'h13579BDF, 32'h0);
        bus_read(5'd12, rd); check(rd[0] == 1'b1, "R8 start reads busy", rd, 32'h35);
        bus_write(5'd16, 32'hDEADBEEF);
        bus_write(5'd12, 32'h00000001);
        bus_write(5'd0, 32'h150);
        wait_done();
        bus_read(5'd16, rd); check(rd == 32'h13579BDF, "R9 data write ignored", rd, 32'h13579BDF);
        check(mosi_cap == 32'h13579BDF, "R9 length unchanged", mosi_cap, 32'h13579BDF);
        check(gap == 64, "R3 rate latched at start", 32'(gap), 32'd64);
        bus_read(5'd12, rd); check(rd == 32'h34, "R9 R8 control after end", rd, 32'h34);

        // R4 mode 1 does not launch
        bus_write(5'd0, 32'h158);
        rise_cnt = 0;
        bus_write(5'd12, 32'h37);
        repeat (20) @(negedge clk);
        check(rise_cnt == 0, "R4 no clock in mode 1", 32'(rise_cnt), 0);
        bus_read(5'd0, rd);  check(rd[3] == 1'b0, "R4 no completion", rd, 0);
        bus_read(5'd12, rd); check(rd[0] == 1'b0, "R4 start reads 0", rd, 32'h36);

        // R2 release, R7 MOSI timing
        bus_write(5'd0, 32'h0);
        check(cs_n == 3'b111, "R2 release", 32'(cs_n), 32'h7);
        check(mosi_bad == 0, "R7 mosi moved while sclk high", 32'(mosi_bad), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule